// File: doc/BRIEF.md
# Ramp-Sense Timing Level Classifier

During a ramped-voltage read of a resistive multi-level cell, the current through the cell rises until a sense comparator reports that it has reached the reference level. A low-resistance cell trips the comparator early and a high-resistance cell trips it late. This block turns the clock cycle in which that comparator flag first appears into a stored 2-bit value. A one-cycle start request begins a read, and a cycle counter runs while the ramp rises. Each sampling deadline splits the timeline into windows, and each window maps to one cell value.

Two decoding modes exist. The four-level mode uses three deadlines and packs two bits per cell. The three-level mode uses two much earlier deadlines, so its read ends far sooner. Its middle window returns a marker for an intermediate level, and a downstream block later resolves that marker to an exact value. In both modes the read stops at the last deadline of the selected mode. The result and a one-cycle done strobe come out on the next cycle.

Top module: `rsc_classifier`

## Requirements
- R1: While reset is held and after it is released, rd_done, rd_value and rd_mid are all 0 until the first read completes.
- R2: When rd_mode=0 (four-level), a flag first sampled at count t with t < ML_D1 yields rd_value=2'b11 and rd_mid=0. Count 0 is the first cycle after the edge that accepted rd_start.
- R3: When rd_mode=0, a flag first sampled at count t with ML_D1 <= t < ML_D2 yields rd_value=2'b10. A flag exactly on ML_D1 belongs to this window.
- R4: When rd_mode=0, a flag first sampled at count t with ML_D2 <= t < ML_D3 yields rd_value=2'b01.
- R5: When rd_mode=0, if no flag is sampled at any count below ML_D3, rd_value=2'b00. A flag exactly at ML_D3 counts as no flag.
- R6: rd_done is high for exactly one cycle. It appears right after the (L+1)-th rising edge that follows the edge that accepted rd_start, where L is ML_D3 in four-level mode and TL_D2 in three-level mode.
- R7: When rd_mode=1 (three-level), a flag at t < TL_D1 yields 2'b11 with rd_mid=0. A flag at TL_D1 <= t < TL_D2 yields the intermediate marker rd_value=2'b01 with rd_mid=1. No flag below TL_D2 yields 2'b00 with rd_mid=0.
- R8: rd_mid is 0 for every four-level result, and rd_mid=1 occurs only together with rd_value=2'b01.
- R9: Only the first cycle in which the flag is high during a read is timed. Later flag pulses in the same read do not change the result.
- R10: An rd_start received while a read is in progress is ignored. The current read keeps its timing and yields a single done strobe.
- R11: rd_mode is sampled only on the edge that accepts rd_start. Changing it during a read affects neither the windows nor the read length.
- R12: rd_value and rd_mid keep their values between done strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_start | input | 1 | One-cycle request to begin a read |
| rd_mode | input | 1 | 0 = four-level decoding, 1 = three-level decoding |
| sense_flag | input | 1 | Comparator output: cell current has reached the reference |
| rd_value | output | 2 | Decoded cell value of the last read |
| rd_mid | output | 1 | Set when the three-level middle window was hit |
| rd_done | output | 1 | One-cycle strobe: rd_value and rd_mid are new |

## Verification
The hardest cases to reach are a flag that rises exactly on a deadline cycle and a new start request that arrives in the middle of a read. Both depend on the position of a single cycle, counted from the edge that accepted the start. The stimulus task counts cycles from that edge. It places each flag pulse, second pulse, repeated start and mode change at an exact count. This lets the bench hit each side of every deadline, including the final one, where the flag must be treated as absent.

// File: rtl/rsc_pkg.sv
// Package rsc_pkg
// Shared types for the ramp-sense classifier: the mode encoding and the
// packed result that passes from the decoder to the output register.
package rsc_pkg;

    typedef enum logic {
        SENSE_4L = 1'b0,
        SENSE_3L = 1'b1
    } sense_mode_e;

    typedef struct packed {
        logic [1:0] code;
        logic       mid;
    } sense_result_t;

    localparam logic [1:0] CODE_LOW_R  = 2'b11;
    localparam logic [1:0] CODE_MID_HI = 2'b10;
    localparam logic [1:0] CODE_MID_LO = 2'b01;
    localparam logic [1:0] CODE_HIGH_R = 2'b00;

endpackage

// File: rtl/rsc_ramp_timer.sv
// Module rsc_ramp_timer
// Owns the read interval. It accepts a start only when idle, latches the
// mode, counts cycles from 0 and flags the final count (the last deadline
// of the latched mode). Assumes the deadlines fit in CNT_W bits.
module rsc_ramp_timer
    import rsc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LAST4  = 132,
    parameter int LAST3  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    output logic             accept,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output sense_mode_e      mode_q,
    output logic             final_tick
);

    localparam logic [CNT_W-1:0] LAST4_C = CNT_W'(LAST4);
    localparam logic [CNT_W-1:0] LAST3_C = CNT_W'(LAST3);

    logic [CNT_W-1:0] last_cnt;

    // Select the final count for the latched mode.
    always_comb begin
        last_cnt = (mode_q == SENSE_3L) ? LAST3_C : LAST4_C;
    end

    assign accept     = start && !busy;
    assign final_tick = busy && (cnt == last_cnt);

    // Sequence the read: start when idle, count, stop at the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            mode_q <= SENSE_4L;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= '0;
            mode_q <= sense_mode_e'(mode);
        end else if (busy) begin
            if (final_tick) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsc_flag_capture.sv
// Module rsc_flag_capture
// Records the count of the first cycle in which the comparator flag is
// high during a read. Later pulses are ignored. A flag on the final count
// is not recorded, because it falls in the window after the last deadline.
module rsc_flag_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sample_en,
    input  logic             flag,
    input  logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic [CNT_W-1:0] hit_t
);

    // Clear on a new read; latch the first flagged count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit   <= 1'b0;
            hit_t <= '0;
        end else if (arm) begin
            hit   <= 1'b0;
            hit_t <= '0;
        end else if (sample_en && flag && !hit) begin
            hit   <= 1'b1;
            hit_t <= cnt;
        end
    end

endmodule

// File: rtl/rsc_level_decode.sv
// Module rsc_level_decode
// Combinational mapping from the captured arrival count to a cell value.
// A comparator bank per mode marks which deadlines the arrival has passed.
// An arrival on a deadline counts as past it. Assumes that the deadlines of
// each mode increase strictly.
module rsc_level_decode
    import rsc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int ML_D1 = 5,
    parameter int ML_D2 = 11,
    parameter int ML_D3 = 132,
    parameter int TL_D1 = 5,
    parameter int TL_D2 = 24
) (
    input  logic             hit,
    input  logic [CNT_W-1:0] hit_t,
    input  sense_mode_e      mode,
    output sense_result_t    result
);

    localparam int N4 = 3;
    localparam int N3 = 2;
    localparam logic [CNT_W-1:0] DL4 [N4] = '{CNT_W'(ML_D1), CNT_W'(ML_D2), CNT_W'(ML_D3)};
    localparam logic [CNT_W-1:0] DL3 [N3] = '{CNT_W'(TL_D1), CNT_W'(TL_D2)};

    logic [N4-1:0] past4;
    logic [N3-1:0] past3;

    genvar g;
    generate
        for (g = 0; g < N4; g++) begin : g_cmp4
            assign past4[g] = (hit_t >= DL4[g]);
        end
        for (g = 0; g < N3; g++) begin : g_cmp3
            assign past3[g] = (hit_t >= DL3[g]);
        end
    endgenerate

    // Pick the window code for the active mode.
    always_comb begin
        result = '{code: CODE_HIGH_R, mid: 1'b0};
        if (mode == SENSE_4L) begin
            if (hit && !past4[2]) begin
                if (past4[1])      result.code = CODE_MID_LO;
                else if (past4[0]) result.code = CODE_MID_HI;
                else               result.code = CODE_LOW_R;
            end
        end else begin
            if (hit && !past3[1]) begin
                if (past3[0]) begin
                    result.code = CODE_MID_LO;
                    result.mid  = 1'b1;
                end else begin
                    result.code = CODE_LOW_R;
                end
            end
        end
    end

endmodule

// File: rtl/rsc_classifier.sv
// Module rsc_classifier (top)
// Ramp-sense timing level classifier. It times the first comparator flag
// of a read against mode-specific deadlines and registers the decoded value
// together with a one-cycle done strobe. Assumes rd_start is a pulse and that
// sense_flag is synchronous to clk.
module rsc_classifier
    import rsc_pkg::*;
#(
    parameter int ML_D1 = 5,
    parameter int ML_D2 = 11,
    parameter int ML_D3 = 132,
    parameter int TL_D1 = 5,
    parameter int TL_D2 = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_start,
    input  logic       rd_mode,
    input  logic       sense_flag,
    output logic [1:0] rd_value,
    output logic       rd_mid,
    output logic       rd_done
);

    localparam int MAX_DL = (ML_D3 > TL_D2) ? ML_D3 : TL_D2;
    localparam int CNT_W  = $clog2(MAX_DL + 1) + 1;

    logic             accept;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    sense_mode_e      mode_q;
    logic             final_tick;
    logic             hit;
    logic [CNT_W-1:0] hit_t;
    sense_result_t    result;

    rsc_ramp_timer #(
        .CNT_W (CNT_W),
        .LAST4 (ML_D3),
        .LAST3 (TL_D2)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_start),
        .mode       (rd_mode),
        .accept     (accept),
        .busy       (busy),
        .cnt        (cnt),
        .mode_q     (mode_q),
        .final_tick (final_tick)
    );

    rsc_flag_capture #(
        .CNT_W (CNT_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (accept),
        .sample_en (busy && !final_tick),
        .flag      (sense_flag),
        .cnt       (cnt),
        .hit       (hit),
        .hit_t     (hit_t)
    );

    rsc_level_decode #(
        .CNT_W (CNT_W),
        .ML_D1 (ML_D1),
        .ML_D2 (ML_D2),
        .ML_D3 (ML_D3),
        .TL_D1 (TL_D1),
        .TL_D2 (TL_D2)
    ) u_decode (
        .hit    (hit),
        .hit_t  (hit_t),
        .mode   (mode_q),
        .result (result)
    );

    // Register the result and pulse done when the read ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_value <= 2'b00;
            rd_mid   <= 1'b0;
            rd_done  <= 1'b0;
        end else begin
            rd_done <= final_tick;
            if (final_tick) begin
                rd_value <= result.code;
                rd_mid   <= result.mid;
            end
        end
    end

endmodule

// File: rtl/rsc_classifier_chk.sv
// Module rsc_classifier_chk
// Protocol checks on the classifier, attached to every instance by bind.
module rsc_classifier_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             mode_q,
    input logic             done,
    input logic [1:0]       value,
    input logic             mid
);

    // R6
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    count_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt == '0));

    // R8
    mid_only_3l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mid) |-> (mode_q == 1'b1));

    // R8
    mid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid |-> (value == 2'b01));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (!busy || cnt != '0));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(value) && $stable(mid)));

endmodule

bind rsc_classifier rsc_classifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rd_start),
    .busy   (busy),
    .cnt    (cnt),
    .mode_q (mode_q),
    .done   (rd_done),
    .value  (rd_value),
    .mid    (rd_mid)
);

// File: tb/rsc_classifier_tb.sv
`timescale 1ns/1ps
module rsc_classifier_tb;

    localparam int D41 = 5, D42 = 11, D43 = 132, D31 = 5, D32 = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_start = 1'b0;
    logic       rd_mode = 1'b0;
    logic       sense_flag = 1'b0;
    logic [1:0] rd_value;
    logic       rd_mid;
    logic       rd_done;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rsc_classifier #(
        .ML_D1(D41), .ML_D2(D42), .ML_D3(D43), .TL_D1(D31), .TL_D2(D32)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_mode(rd_mode),
        .sense_flag(sense_flag), .rd_value(rd_value), .rd_mid(rd_mid),
        .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One read. Pulses are placed at exact counts after the accepting edge;
    // -1 disables an event.
    task automatic run_read(input logic m, input int first, input int second,
                            input int restart_at, input bit flip,
                            input logic [1:0] exp_v, input logic exp_mid,
                            input string req);
        int last = m ? D32 : D43;
        int done_k = -1;
        int ndone = 0;
        @(negedge clk);
        rd_mode = m; rd_start = 1'b1; sense_flag = 1'b0;
        @(negedge clk);
        rd_start = 1'b0;
        for (int k = 0; k <= last + 3; k++) begin
            sense_flag = (k == first) || (k == second);
            rd_start   = (k == restart_at);
            if (flip && k == 1) rd_mode = ~m;
            @(posedge clk); #1;
            if (rd_done) begin
                ndone++;
                if (done_k < 0) done_k = k;
            end
            if (k == last) begin
                chk(rd_value == exp_v, {req, " value"}, rd_value, exp_v);
                chk(rd_mid == exp_mid, {req, " mid"}, rd_mid, exp_mid);
            end
            @(negedge clk);
        end
        sense_flag = 1'b0; rd_start = 1'b0; rd_mode = m;
        chk(done_k == last, {req, " R6 done cycle"}, done_k, last);
        chk(ndone == 1, {req, " R6 single done"}, ndone, 1);
        // R12: result held after the strobe
        chk(rd_value == exp_v && rd_mid == exp_mid, {req, " R12 hold"},
            {rd_value, rd_mid}, {exp_v, exp_mid});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rd_done == 0 && rd_value == 0 && rd_mid == 0, "R1 in reset",
            {rd_done, rd_value, rd_mid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_done == 0 && rd_value == 0 && rd_mid == 0, "R1 after reset",
            {rd_done, rd_value, rd_mid}, 0);
    endtask

    task automatic t_four_level();
        run_read(1'b0, 0,       -1, -1, 0, 2'b11, 1'b0, "R2 t=0");
        run_read(1'b0, D41 - 1, -1, -1, 0, 2'b11, 1'b0, "R2 t=D1-1");
        run_read(1'b0, D41,     -1, -1, 0, 2'b10, 1'b0, "R3 t=D1");
        run_read(1'b0, D42 - 1, -1, -1, 0, 2'b10, 1'b0, "R3 t=D2-1");
        run_read(1'b0, D42,     -1, -1, 0, 2'b01, 1'b0, "R4 t=D2");
        run_read(1'b0, D43 - 1, -1, -1, 0, 2'b01, 1'b0, "R4 R8 t=D3-1");
        run_read(1'b0, D43,     -1, -1, 0, 2'b00, 1'b0, "R5 t=D3");
        run_read(1'b0, -1,      -1, -1, 0, 2'b00, 1'b0, "R5 none");
    endtask

    task automatic t_three_level();
        run_read(1'b1, D31 - 1, -1, -1, 0, 2'b11, 1'b0, "R7 low");
        run_read(1'b1, D31,     -1, -1, 0, 2'b01, 1'b1, "R7 R8 mid at D1");
        run_read(1'b1, D32 - 1, -1, -1, 0, 2'b01, 1'b1, "R7 mid at D2-1");
        run_read(1'b1, D32,     -1, -1, 0, 2'b00, 1'b0, "R7 at D2");
        run_read(1'b1, -1,      -1, -1, 0, 2'b00, 1'b0, "R7 none");
    endtask

    task automatic t_first_flag();
        run_read(1'b0, 7, 20, -1, 0, 2'b10, 1'b0, "R9 later pulse 4l");
        run_read(1'b1, 2, 10, -1, 0, 2'b11, 1'b0, "R9 later pulse 3l");
    endtask

    task automatic t_busy_start();
        run_read(1'b1, 8, -1, 10, 0, 2'b01, 1'b1, "R10 start while busy");
        run_read(1'b0, 3, -1, 50, 0, 2'b11, 1'b0, "R10 start while busy 4l");
    endtask

    task automatic t_mode_change();
        run_read(1'b1, 30, -1, -1, 1, 2'b00, 1'b0, "R11 mode flip 3l");
        run_read(1'b0, 12, -1, -1, 1, 2'b01, 1'b0, "R11 mode flip 4l");
    endtask

    initial begin
        #2_000_000;
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_four_level();
        t_three_level();
        t_first_flag();
        t_busy_start();
        t_mode_change();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule